// File: doc/BRIEF.md
# Multi-Input Link Activity Detector

This block watches the clock lane of each of three serial video inputs and decides which of them carries a usable link. Each lane clock is brought into the reference clock domain through a synchronizer. The block then counts its rising edges over a gate window whose length is set in reference clock cycles. A lane is judged present when its count lies inside a programmable band, with both limits inclusive. A lane's activity flag only changes after two windows in a row give the same verdict, so a single disturbed window leaves it unchanged.

The per-lane flags drive an automatic input choice: the lowest-numbered active lane wins, and the choice is held while no lane is active. Software can override the choice through a register. Every change of a lane's flag sets a sticky event bit. An interrupt is raised while any event bit that the enable mask allows is set. A simple host port with one write strobe and a combinational read path gives access to the registers.

Top module: `link_activity_monitor`

## Requirements
- R1: After reset the activity flags are 0, the selected lane is 0, the interrupt is low, the mode, event and enable registers read 0, and the gate length, lower limit and upper limit read their defaults of 100, 5 and 15.
- R2: A lane whose edge count in one window lies between the lower and upper limit becomes active, with both limits inclusive. A lane whose count exceeds the upper limit stays inactive.
- R3: A lane whose count lies below the lower limit, including a stopped lane clock, is inactive.
- R4: A lane's flag changes only at the end of a window and only when two consecutive windows agree. A gap shorter than one window in an otherwise valid clock leaves the flag and its event bit unchanged.
- R5: The gate length register (address 0) sets the window length in reference cycles, with a minimum of 2. Shortening the window scales the edge count down accordingly.
- R6: In automatic mode (address 3, bit 0 = 0) the selection becomes the lowest-numbered active lane.
- R7: In automatic mode, while no lane is active, the selection keeps its previous value.
- R8: In manual mode (address 3, bit 0 = 1) the selection follows the index in address 3 bits 2:1. An index of 3 or more is ignored and the selection is held.
- R9: Each change of a lane's flag sets that lane's bit in the event register (address 4, bits 2:0). The bit stays set until 1 is written to it, and writing 1 clears only the bits written.
- R10: The interrupt is high exactly when an event bit is set whose enable bit (address 5, bits 2:0) is 1.
- R11: The lower limit (address 1) and upper limit (address 2) are writable and read back. The status register (address 6) reads the flags in bits 2:0 and the selected lane in bits 5:4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock that times the windows and all registers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lane_clk | input | NUM_IN | Clock lane of each serial input, asynchronous to clk_ref |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | CNT_W | Write data |
| host_rdata | output | CNT_W | Read data of the addressed register |
| lane_active | output | NUM_IN | Per-lane activity flag |
| lane_sel | output | SEL_W | Selected lane index |
| irq | output | 1 | Interrupt, OR of the enabled event bits |

## Verification
The hardest case to reach is the hysteresis. The bench has to disturb exactly one window so that the count leaves the band, while it cannot see where the windows start. It does this by stopping a lane clock for 60 reference cycles inside 100-cycle windows. Whichever way the gap falls across the window edges, at most one window loses enough edges to drop out of the band, so the flag must hold. The inclusive limits are reached by placing every lane clock edge half a reference period away from the sampling edges. A 20 ns lane clock then gives exactly 10 edges in a 40-cycle window, and the bench sets both limits to 10 and then moves the lower limit to 11.

// File: rtl/lam_pkg.sv
package lam_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_GATE   = 3'd0,
    RA_LO     = 3'd1,
    RA_HI     = 3'd2,
    RA_MODE   = 3'd3,
    RA_EVENT  = 3'd4,
    RA_ENABLE = 3'd5,
    RA_STATUS = 3'd6
  } reg_addr_e;

  localparam int unsigned STATUS_SEL_LSB = 4;
endpackage

// File: rtl/lam_gate_timer.sv
module lam_gate_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] gate_len,
  output logic             win_end
);
  logic [CNT_W-1:0] cnt_q, cnt_d, last_idx;

  always_comb begin
    last_idx = (gate_len < CNT_W'(2)) ? CNT_W'(1) : gate_len - CNT_W'(1);
    win_end  = (cnt_q >= last_idx);
    cnt_d    = win_end ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_window_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> !win_end);
endmodule

// File: rtl/lam_lane_meter.sv
module lam_lane_meter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lane_clk,
  input  logic             win_end,
  input  logic [CNT_W-1:0] lo_lim,
  input  logic [CNT_W-1:0] hi_lim,
  output logic             active
);
  localparam logic [CNT_W:0] SAT = {1'b0, {CNT_W{1'b1}}};

  logic [2:0]       sync_q;
  logic             rise;
  logic [CNT_W-1:0] edge_q, edge_d, total;
  logic [CNT_W:0]   sum;
  logic             in_band;
  logic             prev_q, prev_d, act_q, act_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], lane_clk};
  end

  always_comb begin
    rise    = sync_q[1] & ~sync_q[2];
    sum     = {1'b0, edge_q} + {{CNT_W{1'b0}}, rise};
    total   = (sum > SAT) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    in_band = (total >= lo_lim) && (total <= hi_lim);
    edge_d  = win_end ? '0 : total;
    prev_d  = prev_q;
    act_d   = act_q;
    if (win_end) begin
      prev_d = in_band;
      if (in_band == prev_q) act_d = in_band;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      prev_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      edge_q <= edge_d;
      prev_q <= prev_d;
      act_q  <= act_d;
    end
  end

  assign active = act_q;

  p_flag_only_at_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(active));
  p_flag_needs_agreement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && (in_band != prev_q)) |=> $stable(active));
endmodule

// File: rtl/lam_input_select.sv
module lam_input_select #(
  parameter int unsigned NUM_IN = 3,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] active,
  input  logic              manual,
  input  logic [SEL_W-1:0]  man_idx,
  output logic [SEL_W-1:0]  sel
);
  logic [SEL_W-1:0] sel_q, sel_d, lowest;

  always_comb begin
    lowest = sel_q;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (active[i]) lowest = SEL_W'(i);
    end
    if (manual) sel_d = (int'(man_idx) < int'(NUM_IN)) ? man_idx : sel_q;
    else        sel_d = lowest;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign sel = sel_q;

  p_sel_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel) < int'(NUM_IN));
  p_manual_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (manual && (int'(man_idx) < int'(NUM_IN))) |=> (sel == $past(man_idx)));
  p_auto_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual && active[0]) |=> (sel == '0));
  p_auto_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual && (active == '0)) |=> $stable(sel));
endmodule

// File: rtl/link_activity_monitor.sv
module link_activity_monitor #(
  parameter int unsigned NUM_IN   = 3,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DEF_GATE = 100,
  parameter int unsigned DEF_LO   = 5,
  parameter int unsigned DEF_HI   = 15,
  localparam int unsigned SEL_W   = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] lane_clk,
  input  logic              host_we,
  input  logic [2:0]        host_addr,
  input  logic [CNT_W-1:0]  host_wdata,
  output logic [CNT_W-1:0]  host_rdata,
  output logic [NUM_IN-1:0] lane_active,
  output logic [SEL_W-1:0]  lane_sel,
  output logic              irq
);
  import lam_pkg::*;

  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic [CNT_W-1:0]  gate_q, gate_d, lo_q, lo_d, hi_q, hi_d;
  logic              man_q, man_d;
  logic [SEL_W-1:0]  idx_q, idx_d;
  logic [NUM_IN-1:0] evt_q, evt_d, en_q, en_d, act_q, change;
  logic              win_end;

  lam_gate_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk_ref), .rst_n(rst_i_n), .gate_len(gate_q), .win_end(win_end));

  for (genvar g = 0; g < NUM_IN; g++) begin : g_meter
    lam_lane_meter #(.CNT_W(CNT_W)) u_meter (
      .clk(clk_ref), .rst_n(rst_i_n), .lane_clk(lane_clk[g]), .win_end(win_end),
      .lo_lim(lo_q), .hi_lim(hi_q), .active(lane_active[g]));
  end

  lam_input_select #(.NUM_IN(NUM_IN), .SEL_W(SEL_W)) u_select (
    .clk(clk_ref), .rst_n(rst_i_n), .active(lane_active), .manual(man_q),
    .man_idx(idx_q), .sel(lane_sel));

  always_comb begin
    gate_d = gate_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    man_d  = man_q;
    idx_d  = idx_q;
    en_d   = en_q;
    change = lane_active ^ act_q;
    evt_d  = evt_q | change;
    if (host_we) begin
      case (reg_addr_e'(host_addr))
        RA_GATE:   gate_d = host_wdata;
        RA_LO:     lo_d   = host_wdata;
        RA_HI:     hi_d   = host_wdata;
        RA_MODE: begin
          man_d = host_wdata[0];
          idx_d = host_wdata[SEL_W:1];
        end
        RA_EVENT:  evt_d  = (evt_q & ~host_wdata[NUM_IN-1:0]) | change;
        RA_ENABLE: en_d   = host_wdata[NUM_IN-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk_ref or negedge rst_i_n) begin
    if (!rst_i_n) begin
      gate_q <= CNT_W'(DEF_GATE);
      lo_q   <= CNT_W'(DEF_LO);
      hi_q   <= CNT_W'(DEF_HI);
      man_q  <= 1'b0;
      idx_q  <= '0;
      evt_q  <= '0;
      en_q   <= '0;
      act_q  <= '0;
    end else begin
      gate_q <= gate_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      man_q  <= man_d;
      idx_q  <= idx_d;
      evt_q  <= evt_d;
      en_q   <= en_d;
      act_q  <= lane_active;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (reg_addr_e'(host_addr))
      RA_GATE:   host_rdata = gate_q;
      RA_LO:     host_rdata = lo_q;
      RA_HI:     host_rdata = hi_q;
      RA_MODE:   host_rdata[SEL_W:0] = {idx_q, man_q};
      RA_EVENT:  host_rdata[NUM_IN-1:0] = evt_q;
      RA_ENABLE: host_rdata[NUM_IN-1:0] = en_q;
      RA_STATUS: begin
        host_rdata[NUM_IN-1:0] = lane_active;
        host_rdata[STATUS_SEL_LSB +: SEL_W] = lane_sel;
      end
      default:   host_rdata = '0;
    endcase
  end

  assign irq = |(evt_q & en_q);

  p_event_captures_change_r9: assert property (@(posedge clk_ref) disable iff (!rst_i_n)
    (lane_active != act_q) |=> ((evt_q & $past(lane_active ^ act_q)) == $past(lane_active ^ act_q)));
  p_event_sticky_r9: assert property (@(posedge clk_ref) disable iff (!rst_i_n)
    (!host_we || (reg_addr_e'(host_addr) != RA_EVENT)) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
endmodule

// File: tb/test_link_activity_monitor.sv
`timescale 1ns/1ps
module test_link_activity_monitor;
  logic        clk;
  logic        rst_n;
  logic [2:0]  lane_clk;
  logic        host_we;
  logic [2:0]  host_addr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic [2:0]  lane_active;
  logic [1:0]  lane_sel;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  real half_ns [3];

  typedef struct {
    string       req;
    bit          use_irq;
    logic [15:0] exp;
  } sb_item_t;

  sb_item_t sb[$];

  link_activity_monitor i_link_activity_monitor (
    .clk_ref(clk), .rst_n(rst_n), .lane_clk(lane_clk), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .lane_active(lane_active), .lane_sel(lane_sel), .irq(irq));

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  for (genvar g = 0; g < 3; g++) begin : g_lane
    logic lc;
    initial begin
      lc = 1'b0;
      forever begin
        if (half_ns[g] == 0.0) #5;
        else begin
          #(half_ns[g]);
          lc = ~lc;
        end
      end
    end
    assign lane_clk[g] = lc;
  end

  // monitor: pops expected items and compares one ns after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        sb_item_t it;
        logic [15:0] got;
        it  = sb.pop_front();
        got = it.use_irq ? {15'd0, irq} : host_rdata;
        checks++;
        if (got !== it.exp) begin
          failures++;
          $display("FAIL %s: got 0x%0h expected 0x%0h", it.req, got, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr  = a;
    host_wdata = d;
    host_we    = 1'b1;
    @(negedge clk);
    host_we    = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [15:0] e);
    @(negedge clk);
    host_addr = a;
    sb.push_back('{req: req, use_irq: 1'b0, exp: e});
    wait (sb.size() == 0);
  endtask

  task automatic expect_irq(input string req, input logic e);
    @(negedge clk);
    sb.push_back('{req: req, use_irq: 1'b1, exp: {15'd0, e}});
    wait (sb.size() == 0);
  endtask

  function automatic logic [15:0] stat(input logic [2:0] act, input logic [1:0] s);
    return {10'd0, s, 1'b0, act};
  endfunction

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    half_ns[0] = 0.0; half_ns[1] = 0.0; half_ns[2] = 0.0;
    settle(5);
    rst_n = 1'b1;
    settle(5);

    // R1 reset state
    expect_reg("R1 status", 3'd6, 16'd0);
    expect_reg("R1 gate", 3'd0, 16'd100);
    expect_reg("R1 lower", 3'd1, 16'd5);
    expect_reg("R1 upper", 3'd2, 16'd15);
    expect_reg("R1 mode", 3'd3, 16'd0);
    expect_reg("R1 event", 3'd4, 16'd0);
    expect_reg("R1 enable", 3'd5, 16'd0);
    expect_irq("R1 irq", 1'b0);

    // R2/R3: lane0 10 edges (in band), lane1 25 (above), lane2 2-3 (below)
    @(negedge clk);
    half_ns[0] = 25.0; half_ns[1] = 10.0; half_ns[2] = 100.0;
    settle(600);
    expect_reg("R2 R3 R6 status", 3'd6, stat(3'b001, 2'd0));
    expect_reg("R9 event set", 3'd4, 16'h0001);
    expect_irq("R10 masked", 1'b0);

    // R10 enable, R9 write-one-to-clear
    wr(3'd5, 16'h0001);
    expect_irq("R10 enabled", 1'b1);
    wr(3'd4, 16'h0006);
    expect_reg("R9 other bits clear nothing", 3'd4, 16'h0001);
    wr(3'd4, 16'h0001);
    expect_reg("R9 cleared", 3'd4, 16'h0000);
    expect_irq("R10 after clear", 1'b0);

    // R4: 60-cycle gap in lane0
    @(negedge clk);
    half_ns[0] = 0.0;
    settle(60);
    half_ns[0] = 25.0;
    settle(600);
    expect_reg("R4 flag held", 3'd6, stat(3'b001, 2'd0));
    expect_reg("R4 no event", 3'd4, 16'h0000);

    // R5 and R6: 40-cycle window, lanes 0 and 1 at 20 ns give 10 edges
    @(negedge clk);
    host_addr = 3'd0; host_wdata = 16'd40; host_we = 1'b1;
    half_ns[0] = 10.0;
    @(negedge clk);
    host_we = 1'b0;
    settle(600);
    expect_reg("R5 R6 two active lowest wins", 3'd6, stat(3'b011, 2'd0));
    wr(3'd4, 16'h0007);

    // R6: only lane2
    @(negedge clk);
    half_ns[0] = 0.0; half_ns[1] = 0.0; half_ns[2] = 10.0;
    settle(600);
    expect_reg("R6 R3 only lane2", 3'd6, stat(3'b100, 2'd2));
    wr(3'd4, 16'h0007);

    // R7: everything stops
    @(negedge clk);
    half_ns[2] = 0.0;
    settle(600);
    expect_reg("R7 selection held", 3'd6, stat(3'b000, 2'd2));
    expect_reg("R9 lane2 event", 3'd4, 16'h0004);
    expect_irq("R10 lane2 masked", 1'b0);

    // R8 manual override
    wr(3'd3, 16'h0003);
    expect_reg("R8 manual index 1", 3'd6, stat(3'b000, 2'd1));
    wr(3'd3, 16'h0007);
    expect_reg("R8 index 3 ignored", 3'd6, stat(3'b000, 2'd1));
    wr(3'd3, 16'h0000);
    expect_reg("R7 auto hold", 3'd6, stat(3'b000, 2'd1));

    // R11 and R2 inclusive bounds: lane1 gives exactly 10 edges
    wr(3'd4, 16'h0007);
    wr(3'd1, 16'd10);
    wr(3'd2, 16'd10);
    expect_reg("R11 lower readback", 3'd1, 16'd10);
    expect_reg("R11 upper readback", 3'd2, 16'd10);
    @(negedge clk);
    half_ns[1] = 10.0;
    settle(600);
    expect_reg("R2 inclusive limits", 3'd6, stat(3'b010, 2'd1));
    wr(3'd1, 16'd11);
    settle(600);
    expect_reg("R11 raised lower limit", 3'd6, stat(3'b000, 2'd1));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule